// File: doc/BRIEF.md
# Radix-4 Carry-Save SRT Fractional Divider

This block divides one normalized fixed-point operand by another and produces one radix-4 quotient digit per clock cycle. Both operands are unsigned words whose top bit is always set, so each one reads as a value in [1, 2) with one integer bit. Each quotient digit is taken from the redundant set {-2, -1, 0, +1, +2}. The partial remainder is kept as two vectors, a sum vector and a carry vector, and each iteration updates them with a single carry-save layer. No carry has to cross the full width inside a step.

The digit for the next step comes from an 8-bit adder. This adder combines only the top eight bits of the shifted sum vector with the top eight bits of the shifted carry vector. Its result is turned into a sign and a magnitude, then compared against thresholds that depend on three divisor fraction bits. The thresholds are computed at elaboration time, one set for each divisor interval. The signed digits build up in separate positive and negative accumulators. After the last iteration, one extra cycle does three things: it subtracts the two accumulators, resolves the remainder vectors with a full carry-propagate add, and applies a one-step correction when that remainder is negative.

A caller raises `start` for one cycle with the operands while the block is idle. It then waits for the one-cycle `done` pulse and reads `quotient` and `remainder`. Both outputs hold their values until the next result.

Top module: `srt4_divider`

## Requirements
- R1: When reset ends, `busy` and `done` are 0 and `quotient` and `remainder` are all zeros.
- R2: A `start` pulse seen while `busy` is 0 loads the operands, and `busy` is 1 from the next cycle until the result is presented. A `start` pulse or an operand change while `busy` is 1 has no effect on the result being computed.
- R3: `done` is a one-cycle pulse in the ITER+1-th cycle after the clock edge that accepted `start`. `quotient` and `remainder` keep their values from that pulse until the next division completes.
- R4: For dividend X and divisor D, both with bit W-1 set, `quotient` equals floor(X·4^(ITER-1) / D).
- R5: `remainder` equals X·4^(ITER-1) − quotient·D and lies in [0, D).
- R6: Each iteration selects a digit in {-2,…,+2}. The selection uses only two inputs. The first is the 8-bit sum of the top eight bits (sign, three integer bits, four fraction bits) of the shifted sum and carry vectors. The second is divisor bits W-2 down to W-4.
- R7: After every iteration, the assimilated partial remainder r satisfies 3·|r| ≤ 2·D, with both r and D on the remainder scale.
- R8: Equal operands give a quotient of exactly 4^(ITER-1) and a zero remainder. This holds even when the redundant digits leave a negative raw remainder that needs correction.
- R9: Divisors at both ends of each of the eight intervals set by bits W-2..W-4 give results that meet R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a division; accepted only while idle |
| dividend | input | W | Normalized dividend, bit W-1 set |
| divisor | input | W | Normalized divisor, bit W-1 set |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| quotient | output | 2·ITER | Binary quotient, floor(X·4^(ITER-1)/D) |
| remainder | output | W | Final non-negative remainder |

## Verification
The hardest situation to reach is a shifted remainder estimate that lands exactly on a selection threshold while the truncation of both carry-save vectors takes up nearly its full 1/8 error budget. In that case the wrong cell would push the remainder out of the convergence bound. The port alone cannot steer the carry-save split. The stimulus therefore aims at those cells indirectly: it places divisors at both edges of every one of the eight divisor intervals and pairs each with dividends near the ratios where digit boundaries fall (4/3, 5/6, equal operands, and the extremes). Random normalized operands are added on top, while a bound check inside the checker watches every iteration.

// File: rtl/srt4_pkg.sv
// Package srt4_pkg
// Shared types and elaboration-time helpers for the radix-4 SRT divider.
// Thresholds are in units of 1/16 of the shifted remainder estimate.
// The divisor interval index i covers d in [(8+i)/8, (9+i)/8).
package srt4_pkg;

    typedef logic signed [2:0] qdigit_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_t;

    // Smallest estimate magnitude that selects +1: ceil((1/3)*d_hi*16)
    function automatic int thr_pos1(input int idx);
        return (2 * (9 + idx) + 2) / 3;
    endfunction

    // Smallest estimate magnitude that selects +2: ceil((4/3)*d_hi*16)
    function automatic int thr_pos2(input int idx);
        return (8 * (9 + idx) + 2) / 3;
    endfunction

    // Smallest negative magnitude that selects -1: floor((2/3)*d_lo*16)+1
    function automatic int thr_neg1(input int idx);
        return (4 * (8 + idx)) / 3 + 1;
    endfunction

    // Smallest negative magnitude that selects -2: floor((5/3)*d_lo*16)+1
    function automatic int thr_neg2(input int idx);
        return (10 * (8 + idx)) / 3 + 1;
    endfunction

endpackage

// File: rtl/srt4_estimate.sv
// Module srt4_estimate
// Adds the top eight bits of the shifted sum and carry vectors to form a
// truncated estimate of 4*r. Then it splits that estimate into a sign and
// a 7-bit magnitude.
// Assumes: the true value of 4*r lies in (-8, 8), so the 8-bit sum cannot
// wrap. The estimate is at most 1/8 below the true value.
module srt4_estimate (
    input  logic [7:0] sum_top,
    input  logic [7:0] carry_top,
    output logic       est_neg,
    output logic [6:0] est_mag
);

    logic [7:0] est_raw;
    logic [7:0] est_abs;

    // Short assimilation adder over the leading bits only
    always_comb begin
        est_raw = sum_top + carry_top;
    end

    // Two's complement to sign-magnitude conversion
    always_comb begin
        est_neg = est_raw[7];
        est_abs = est_raw[7] ? (~est_raw + 8'd1) : est_raw;
        est_mag = est_abs[6:0];
    end

endmodule

// File: rtl/srt4_digit_sel.sv
// Module srt4_digit_sel
// Picks the next quotient digit from the sign-magnitude estimate and
// three divisor fraction bits. There is one threshold set per divisor
// interval, and each set is computed during elaboration.
// Assumes: the leading divisor bit is 1, so it is not an input.
module srt4_digit_sel
    import srt4_pkg::*;
#(
    parameter int DBITS = 3
) (
    input  logic             est_neg,
    input  logic [6:0]       est_mag,
    input  logic [DBITS-1:0] dfrac,
    output qdigit_t          digit
);

    localparam int NCELL = 1 << DBITS;

    logic [6:0] p1_tab [NCELL];
    logic [6:0] p2_tab [NCELL];
    logic [6:0] n1_tab [NCELL];
    logic [6:0] n2_tab [NCELL];

    // One threshold set per divisor interval
    for (genvar gi = 0; gi < NCELL; gi++) begin : g_cell
        localparam int P1 = thr_pos1(gi);
        localparam int P2 = thr_pos2(gi);
        localparam int N1 = thr_neg1(gi);
        localparam int N2 = thr_neg2(gi);
        assign p1_tab[gi] = 7'(P1);
        assign p2_tab[gi] = 7'(P2);
        assign n1_tab[gi] = 7'(N1);
        assign n2_tab[gi] = 7'(N2);
    end

    logic [6:0] p1_sel, p2_sel, n1_sel, n2_sel;

    // Pick the threshold set for this divisor interval
    always_comb begin
        p1_sel = p1_tab[dfrac];
        p2_sel = p2_tab[dfrac];
        n1_sel = n1_tab[dfrac];
        n2_sel = n2_tab[dfrac];
    end

    // Compare the magnitude against the thresholds for its sign
    always_comb begin
        if (!est_neg) begin
            if (est_mag >= p2_sel)      digit = 3'sd2;
            else if (est_mag >= p1_sel) digit = 3'sd1;
            else                        digit = 3'sd0;
        end else begin
            if (est_mag >= n2_sel)      digit = -3'sd2;
            else if (est_mag >= n1_sel) digit = -3'sd1;
            else                        digit = 3'sd0;
        end
    end

endmodule

// File: rtl/srt4_csa_step.sv
// Module srt4_csa_step
// Forms 4*r - q*D in carry-save form. The inputs are the redundant
// remainder (sum, carry), the scaled divisor and the digit. The +1 of the
// two's complement negation goes into the free carry LSB.
// Assumes: the true result fits in RW bits as a signed value.
module srt4_csa_step
    import srt4_pkg::*;
#(
    parameter int RW = 21
) (
    input  logic [RW-1:0] sum_in,
    input  logic [RW-1:0] carry_in,
    input  logic [RW-1:0] div_in,
    input  qdigit_t       digit,
    output logic [RW-1:0] sum_out,
    output logic [RW-1:0] carry_out
);

    logic [2:0]    neg_digit;
    logic [1:0]    digit_mag;
    logic          do_sub;
    logic [RW-1:0] multiple;
    logic [RW-1:0] addend;
    logic [RW-1:0] sh_sum;
    logic [RW-1:0] sh_carry;
    logic [RW-1:0] majority;

    // Digit magnitude and operation
    always_comb begin
        neg_digit = 3'(-digit);
        digit_mag = digit[2] ? neg_digit[1:0] : digit[1:0];
        do_sub    = !digit[2] && (digit != 3'sd0);
    end

    // Divisor multiple, inverted when it is subtracted
    always_comb begin
        unique case (digit_mag)
            2'd2:    multiple = {div_in[RW-2:0], 1'b0};
            2'd1:    multiple = div_in;
            default: multiple = '0;
        endcase
        addend = do_sub ? ~multiple : multiple;
    end

    // One carry-save layer over the shifted remainder and the addend
    always_comb begin
        sh_sum    = {sum_in[RW-3:0], 2'b00};
        sh_carry  = {carry_in[RW-3:0], 2'b00};
        sum_out   = sh_sum ^ sh_carry ^ addend;
        majority  = (sh_sum & sh_carry) | (sh_sum & addend) | (sh_carry & addend);
        carry_out = {majority[RW-2:0], do_sub};
    end

endmodule

// File: rtl/srt4_qconv.sv
// Module srt4_qconv
// Builds the quotient from signed digits in two radix-4 accumulators: one
// for the positive digits and one for the magnitudes of the negative digits.
// Their difference is the binary quotient before correction.
// Assumes: clear and step are never high together.
module srt4_qconv
    import srt4_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  qdigit_t       digit,
    output logic [QW-1:0] qpos,
    output logic [QW-1:0] qneg
);

    logic [1:0] pos_part;
    logic [1:0] neg_part;
    logic [2:0] neg_digit;

    // Split the digit into its positive and negative contributions
    always_comb begin
        neg_digit = 3'(-digit);
        pos_part  = (!digit[2]) ? digit[1:0] : 2'd0;
        neg_part  = digit[2] ? neg_digit[1:0] : 2'd0;
    end

    // Shift by one radix-4 place and append the new digit
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            qpos <= '0;
            qneg <= '0;
        end else if (step) begin
            qpos <= {qpos[QW-3:0], pos_part};
            qneg <= {qneg[QW-3:0], neg_part};
        end
    end

endmodule

// File: rtl/srt4_divider.sv
// Module srt4_divider
// Iterative radix-4 SRT fractional divider with a carry-save partial
// remainder. It runs ITER digit iterations and then one resolve cycle.
// Remainder scale: 2^-(W+1). The dividend loads as r0 = X/4 and the
// divisor as 4*D. The quotient is floor(X*4^(ITER-1)/D).
// Assumes: both operands have bit W-1 set.
module srt4_divider
    import srt4_pkg::*;
#(
    parameter int W    = 16,
    parameter int ITER = W / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [W-1:0]        dividend,
    input  logic [W-1:0]        divisor,
    output logic                busy,
    output logic                done,
    output logic [2*ITER-1:0]   quotient,
    output logic [W-1:0]        remainder
);

    localparam int RW = W + 5;
    localparam int QW = 2 * ITER;
    localparam int CW = $clog2(ITER + 1);

    div_state_t    state;
    logic [CW-1:0] iter_cnt;
    logic [RW-1:0] sum_q;
    logic [RW-1:0] carry_q;
    logic [RW-1:0] div4_q;
    logic [RW-1:0] sum_nx;
    logic [RW-1:0] carry_nx;
    logic          est_neg;
    logic [6:0]    est_mag;
    qdigit_t       q_dig;
    logic [QW-1:0] qpos;
    logic [QW-1:0] qneg;
    logic          load_go;
    logic          run_step;
    logic          run_phase;
    logic [RW-1:0] rem_raw;
    logic [RW-1:0] rem_fix;
    logic          rem_is_neg;

    // Handshake decode
    always_comb begin
        load_go   = (state == ST_IDLE) && start;
        run_step  = (state == ST_RUN);
        run_phase = (state != ST_IDLE);
        busy      = run_phase;
    end

    srt4_estimate u_est (
        .sum_top   (sum_q[RW-3 -: 8]),
        .carry_top (carry_q[RW-3 -: 8]),
        .est_neg   (est_neg),
        .est_mag   (est_mag)
    );

    srt4_digit_sel #(.DBITS(3)) u_sel (
        .est_neg (est_neg),
        .est_mag (est_mag),
        .dfrac   (div4_q[W:W-2]),
        .digit   (q_dig)
    );

    srt4_csa_step #(.RW(RW)) u_csa (
        .sum_in    (sum_q),
        .carry_in  (carry_q),
        .div_in    (div4_q),
        .digit     (q_dig),
        .sum_out   (sum_nx),
        .carry_out (carry_nx)
    );

    srt4_qconv #(.QW(QW)) u_qconv (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load_go),
        .step  (run_step),
        .digit (q_dig),
        .qpos  (qpos),
        .qneg  (qneg)
    );

    // Final assimilation and sign correction of the remainder
    always_comb begin
        rem_raw    = sum_q + carry_q;
        rem_is_neg = rem_raw[RW-1];
        rem_fix    = rem_is_neg ? (rem_raw + div4_q) : rem_raw;
    end

    // Sequencing, remainder registers and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            iter_cnt  <= '0;
            sum_q     <= '0;
            carry_q   <= '0;
            div4_q    <= '0;
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        sum_q    <= {5'b0, dividend};
                        carry_q  <= '0;
                        div4_q   <= {3'b0, divisor, 2'b00};
                        iter_cnt <= '0;
                        state    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    sum_q    <= sum_nx;
                    carry_q  <= carry_nx;
                    iter_cnt <= iter_cnt + 1'b1;
                    if (iter_cnt == CW'(ITER - 1)) state <= ST_FIN;
                end
                ST_FIN: begin
                    quotient  <= qpos - qneg - QW'(rem_is_neg);
                    remainder <= rem_fix[W+1:2];
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srt4_divider_chk.sv
// Module srt4_divider_chk
// Assertion checker bound to srt4_divider. It watches the handshake, the
// digit range, the per-iteration remainder bound and the final remainder.
module srt4_divider_chk #(
    parameter int W  = 16,
    parameter int RW = W + 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic                run_phase,
    input logic [RW-1:0]       sum_q,
    input logic [RW-1:0]       carry_q,
    input logic [RW-1:0]       div4_q,
    input logic signed [2:0]   q_dig,
    input logic [W-1:0]        remainder
);

    logic [RW-1:0] r_full;
    logic [RW+2:0] r_ext;
    logic [RW+2:0] r_mag;
    logic [RW+2:0] d_ext;

    // Absolute value of the assimilated partial remainder
    always_comb begin
        r_full = sum_q + carry_q;
        r_ext  = {{3{r_full[RW-1]}}, r_full};
        r_mag  = r_ext[RW+2] ? (~r_ext + 1'b1) : r_ext;
        d_ext  = {3'b0, div4_q};
    end

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r3_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r5_remainder_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remainder < div4_q[W+1:2]));

    a_r6_digit_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        run_phase |-> (q_dig >= -3'sd2 && q_dig <= 3'sd2));

    a_r7_remainder_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_phase |-> ((r_mag * 3) <= (d_ext * 2)));

endmodule

bind srt4_divider srt4_divider_chk #(.W(W), .RW(RW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .run_phase (run_phase),
    .sum_q     (sum_q),
    .carry_q   (carry_q),
    .div4_q    (div4_q),
    .q_dig     (q_dig),
    .remainder (remainder)
);

// File: tb/srt4_divider_tb_top.sv
// Directed testbench for srt4_divider: one task per scenario.
module srt4_divider_tb_top;

    localparam int W    = 16;
    localparam int ITER = W / 2;
    localparam int QW   = 2 * ITER;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  dividend = '0;
    logic [W-1:0]  divisor = '0;
    logic          busy;
    logic          done;
    logic [QW-1:0] quotient;
    logic [W-1:0]  remainder;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    srt4_divider #(.W(W), .ITER(ITER)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issue one division, measure latency, compare with integer division
    task automatic run_div(input string req, input logic [W-1:0] x,
                           input logic [W-1:0] d, input bit disturb);
        longint num, eq, er;
        int lat;
        @(negedge clk);
        start = 1'b1; dividend = x; divisor = d;
        lat = -1;
        @(posedge clk); lat++;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R2: start and new operands during busy must be ignored
            check("R2", "busy after start", busy, 1);
            start = 1'b1; dividend = 16'hFFFF; divisor = 16'h8001;
            @(posedge clk); lat++;
            @(negedge clk);
            start = 1'b0; dividend = 16'h8000; divisor = 16'hC000;
        end
        while (!done && lat < 4 * ITER) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        num = longint'(x) << (2 * ITER - 2);
        eq  = num / longint'(d);
        er  = num % longint'(d);
        check("R3", "latency", lat, ITER + 1);
        check(req, "quotient", longint'(quotient), eq);
        check(req, "remainder", longint'(remainder), er);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "quotient", quotient, 0);
        check("R1", "remainder", remainder, 0);
    endtask

    task automatic t_basic();
        run_div("R4", 16'h8000, 16'h8000, 1'b0);
        run_div("R4", 16'hFFFF, 16'h8000, 1'b0);
        run_div("R5", 16'h8000, 16'hFFFF, 1'b0);
        run_div("R5", 16'hA5A5, 16'hC3C3, 1'b0);
    endtask

    task automatic t_hold();
        logic [QW-1:0] q0;
        logic [W-1:0]  r0;
        run_div("R4", 16'hB000, 16'h9000, 1'b0);
        q0 = quotient; r0 = remainder;
        repeat (4) @(negedge clk);
        // R3: outputs hold after the done pulse
        check("R3", "done low after pulse", done, 0);
        check("R3", "quotient held", quotient, q0);
        check("R3", "remainder held", remainder, r0);
    endtask

    task automatic t_busy_ignore();
        run_div("R2", 16'hD123, 16'h9ABC, 1'b1);
        check("R2", "idle after result", busy, 0);
    endtask

    task automatic t_equal();
        logic [W-1:0] vals [4] = '{16'h8000, 16'hAAAB, 16'hC001, 16'hFFFF};
        for (int i = 0; i < 4; i++) begin
            run_div("R8", vals[i], vals[i], 1'b0);
            check("R8", "exact power quotient", longint'(quotient), longint'(1) << (2 * ITER - 2));
        end
    endtask

    // R9, R6, R7: both ends of every divisor interval, dividends near the
    // digit boundaries
    task automatic t_intervals();
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] dlo, dhi, xa;
            longint t;
            dlo = 16'h8000 | (16'(i) << 12);
            dhi = dlo | 16'h0FFF;
            run_div("R9", 16'h8000, dlo, 1'b0);
            run_div("R9", 16'hFFFF, dhi, 1'b0);
            t = (longint'(dlo) * 4) / 3;
            xa = (t > 16'hFFFF) ? 16'hFFFF : 16'(t);
            run_div("R9", xa, dlo, 1'b0);
            t = (longint'(dhi) * 5) / 6;
            xa = (t < 16'h8000) ? 16'h8000 : 16'(t);
            run_div("R9", xa, dhi, 1'b0);
        end
    endtask

    task automatic t_random();
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] x, d;
            x = 16'h8000 | 16'($urandom);
            d = 16'h8000 | 16'($urandom);
            run_div("R4", x, d, 1'b0);
        end
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_basic();
        t_hold();
        t_busy_ignore();
        t_equal();
        t_intervals();
        t_random();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule